// File: doc/BRIEF.md
# Segmented Binary-Thermometer DAC Switch Driver

This block sits between the sample-rate data input of a segmented current-steering converter and its switch cells. On each rising edge of the sample clock it captures a `DATA_W`-bit word and cuts it into two fields. The upper `DATA_W-LSB_W` bits select how many identical unit cells are steered to the positive output. They are expanded into a thermometer code of `2^(DATA_W-LSB_W)-1` lines. The lower `LSB_W` bits drive binary-weighted cells directly.

The binary field goes through a delay line that has as many stages as the decoder. Both groups then pass through one final bank of flip-flops clocked by the sample clock, so every switch line toggles on the same edge. Each line is given as a true and complement pair for a differential switch, and the two rails come from separate flip-flops. The parameter `DEC_PIPE` adds one register stage after the decoder and the same stage to the binary delay line. The end-to-end latency is `LATENCY = 2 + DEC_PIPE` clock edges and is the same for every output line.

Top module: `segdac_datapath`

## Requirements
- R1: The input word is split at bit `LSB_W`. Bits `[DATA_W-1:LSB_W]` form the unary field and bits `[LSB_W-1:0]` form the binary field.
- R2: Unary line `i` (`0 <= i < 2^(DATA_W-LSB_W)-1`) is high exactly when the unary field value is greater than `i`. The lines that are high therefore form a contiguous run starting at bit 0, and their count equals the field value.
- R3: Binary line `j` equals bit `j` of the binary field of the same input word.
- R4: Every true output reflects the word captured `LATENCY = 2 + DEC_PIPE` rising edges earlier. All bits have this same latency, so the unary and binary groups of one word appear together.
- R5: In every cycle, `unary_n` is the bitwise inverse of `unary_p` and `bin_n` is the bitwise inverse of `bin_p`.
- R6: Reset is synchronous and active high. After any edge at which `rst` is high, all true outputs are 0 and all complement outputs are 1. Outputs stay at that code-zero pattern until the first word captured after release arrives.
- R7: With `DEC_PIPE = 0` the latency is 2 edges and with `DEC_PIPE = 1` it is 3 edges. In both settings the two groups stay aligned.
- R8: Input 0 gives all true lines low. The all-ones input gives every unary and binary true line high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous active-high reset |
| din | input | DATA_W | Input sample word |
| unary_p | output | 2^(DATA_W-LSB_W)-1 | Thermometer switch controls, true rail |
| unary_n | output | 2^(DATA_W-LSB_W)-1 | Thermometer switch controls, complement rail |
| bin_p | output | LSB_W | Binary switch controls, true rail |
| bin_n | output | LSB_W | Binary switch controls, complement rail |

## Verification
The following are checked on every clock:
- the two rails are complements of each other;
- the unary group is a contiguous run of ones starting at bit 0;
- outputs hold the code-zero pattern right after reset;
- once `LATENCY` clean edges have passed, the number of unary ones and the binary field both match the word seen exactly `LATENCY` edges before.

The bench scenarios cover what those checks cannot:
- a full ramp through every code, including the field boundaries;
- walking bits in the binary field under a fixed unary value;
- full-scale alternation;
- a reset asserted in the middle of a stream;
- a second instance with the decoder register removed, which shows that the latency changes while alignment holds.

// File: rtl/segdac_pkg.sv
package segdac_pkg;

    // Number of register stages from input pin to switch control.
    function automatic int seg_latency(input int dec_pipe);
        return 2 + dec_pipe;
    endfunction

    // Number of thermometer lines produced from an msb_w-bit field.
    function automatic int unary_lines(input int msb_w);
        return (1 << msb_w) - 1;
    endfunction

    // Decoder stage selection.
    typedef enum int {
        DEC_COMB = 0,
        DEC_REG  = 1
    } dec_mode_e;

endpackage

// File: rtl/segdac_in_reg.sv
module segdac_in_reg #(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= d;
    end
endmodule

// File: rtl/segdac_therm_dec.sv
module segdac_therm_dec
    import segdac_pkg::*;
#(
    parameter int M    = 6,
    parameter int PIPE = 1,
    localparam int U   = unary_lines(M)
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [M-1:0] code,
    output logic [U-1:0] therm
);
    logic [U-1:0] raw;

    // Each line compares the field against its own index.
    for (genvar g = 0; g < U; g++) begin : g_cmp
        assign raw[g] = (int'(code) > g);
    end

    if (PIPE == int'(DEC_REG)) begin : g_reg
        logic [U-1:0] stage_q;
        always_ff @(posedge clk) begin
            if (rst) stage_q <= '0;
            else     stage_q <= raw;
        end
        assign therm = stage_q;
    end else begin : g_comb
        assign therm = raw;
    end
endmodule

// File: rtl/segdac_lsb_delay.sv
module segdac_lsb_delay #(
    parameter int W      = 4,
    parameter int STAGES = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    if (STAGES == 0) begin : g_wire
        assign q = d;
    end else begin : g_line
        logic [W-1:0] tap [STAGES];
        always_ff @(posedge clk) begin
            if (rst) begin
                for (int s = 0; s < STAGES; s++) tap[s] <= '0;
            end else begin
                tap[0] <= d;
                for (int s = 1; s < STAGES; s++) tap[s] <= tap[s-1];
            end
        end
        assign q = tap[STAGES-1];
    end
endmodule

// File: rtl/segdac_out_stage.sv
module segdac_out_stage #(
    parameter int W = 67
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q_p,
    output logic [W-1:0] q_n
);
    // Separate flops for each rail so both switch gates see matched edges.
    always_ff @(posedge clk) begin
        if (rst) begin
            q_p <= '0;
            q_n <= '1;
        end else begin
            q_p <= d;
            q_n <= ~d;
        end
    end
endmodule

// File: rtl/segdac_datapath.sv
module segdac_datapath
    import segdac_pkg::*;
#(
    parameter int  DATA_W   = 10,
    parameter int  LSB_W    = 4,
    parameter int  DEC_PIPE = 1,
    localparam int MSB_W    = DATA_W - LSB_W,
    localparam int UNARY_W  = unary_lines(MSB_W),
    localparam int LATENCY  = seg_latency(DEC_PIPE)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [DATA_W-1:0]  din,
    output logic [UNARY_W-1:0] unary_p,
    output logic [UNARY_W-1:0] unary_n,
    output logic [LSB_W-1:0]   bin_p,
    output logic [LSB_W-1:0]   bin_n
);
    localparam int CTRL_W = UNARY_W + LSB_W;

    typedef struct packed {
        logic [MSB_W-1:0] msb;
        logic [LSB_W-1:0] lsb;
    } word_t;

    typedef struct packed {
        logic [UNARY_W-1:0] th;
        logic [LSB_W-1:0]   bn;
    } ctrl_t;

    word_t cap_w;
    ctrl_t ctrl_d;
    ctrl_t ctrl_p;
    ctrl_t ctrl_n;

    segdac_in_reg #(.W(DATA_W)) u_in (
        .clk (clk),
        .rst (rst),
        .d   (din),
        .q   (cap_w)
    );

    segdac_therm_dec #(.M(MSB_W), .PIPE(DEC_PIPE)) u_dec (
        .clk   (clk),
        .rst   (rst),
        .code  (cap_w.msb),
        .therm (ctrl_d.th)
    );

    segdac_lsb_delay #(.W(LSB_W), .STAGES(DEC_PIPE)) u_dly (
        .clk (clk),
        .rst (rst),
        .d   (cap_w.lsb),
        .q   (ctrl_d.bn)
    );

    segdac_out_stage #(.W(CTRL_W)) u_out (
        .clk (clk),
        .rst (rst),
        .d   (ctrl_d),
        .q_p (ctrl_p),
        .q_n (ctrl_n)
    );

    assign unary_p = ctrl_p.th;
    assign unary_n = ctrl_n.th;
    assign bin_p   = ctrl_p.bn;
    assign bin_n   = ctrl_n.bn;
endmodule

// File: rtl/segdac_datapath_chk.sv
module segdac_datapath_chk #(
    parameter int  DATA_W   = 10,
    parameter int  LSB_W    = 4,
    parameter int  DEC_PIPE = 1,
    localparam int MSB_W    = DATA_W - LSB_W,
    localparam int UNARY_W  = (1 << MSB_W) - 1,
    localparam int LAT      = 2 + DEC_PIPE
) (
    input logic               clk,
    input logic               rst,
    input logic [DATA_W-1:0]  din,
    input logic [UNARY_W-1:0] unary_p,
    input logic [UNARY_W-1:0] unary_n,
    input logic [LSB_W-1:0]   bin_p,
    input logic [LSB_W-1:0]   bin_n
);
    // Number of consecutive non-reset edges, saturating at LAT.
    int clean_cnt;
    always_ff @(posedge clk) begin
        if (rst)                  clean_cnt <= 0;
        else if (clean_cnt < LAT) clean_cnt <= clean_cnt + 1;
    end

    a_r5_rails_inverse: assert property (@(posedge clk) disable iff (rst)
        (clean_cnt > 0) |-> (unary_n == ~unary_p) && (bin_n == ~bin_p));

    a_r2_contiguous_run: assert property (@(posedge clk) disable iff (rst)
        (clean_cnt > 0) |-> ((unary_p & (unary_p + UNARY_W'(1))) == '0));

    a_r6_zero_after_reset: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (unary_p == '0) && (bin_p == '0) && (unary_n == '1) && (bin_n == '1));

    a_r4_aligned_latency: assert property (@(posedge clk) disable iff (rst)
        (clean_cnt >= LAT) |->
            ($countones(unary_p) == int'($past(din[DATA_W-1:LSB_W], LAT))) &&
            (bin_p == $past(din[LSB_W-1:0], LAT)));
endmodule

bind segdac_datapath segdac_datapath_chk #(
    .DATA_W(DATA_W), .LSB_W(LSB_W), .DEC_PIPE(DEC_PIPE)
) u_chk (
    .clk(clk), .rst(rst), .din(din),
    .unary_p(unary_p), .unary_n(unary_n), .bin_p(bin_p), .bin_n(bin_n)
);

// File: tb/sim_segdac_datapath.sv
`timescale 1ns/1ps
module sim_segdac_datapath;
    localparam int DW = 10;
    localparam int LW = 4;
    localparam int MW = DW - LW;
    localparam int UW = (1 << MW) - 1;
    localparam int LAT0 = 3;  // DEC_PIPE = 1
    localparam int LAT1 = 2;  // DEC_PIPE = 0

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [DW-1:0] din = '0;
    logic [UW-1:0] up0, un0, up1, un1;
    logic [LW-1:0] bp0, bn0, bp1, bn1;

    int n_checks = 0;
    int n_fail = 0;
    int q0[$];
    int q1[$];

    always #4 clk = ~clk;

    segdac_datapath #(.DATA_W(DW), .LSB_W(LW), .DEC_PIPE(1)) u0 (
        .clk(clk), .rst(rst), .din(din),
        .unary_p(up0), .unary_n(un0), .bin_p(bp0), .bin_n(bn0));

    segdac_datapath #(.DATA_W(DW), .LSB_W(LW), .DEC_PIPE(0)) u1 (
        .clk(clk), .rst(rst), .din(din),
        .unary_p(up1), .unary_n(un1), .bin_p(bp1), .bin_n(bn1));

    function automatic logic [UW-1:0] therm_of(input int word);
        logic [UW-1:0] t = '0;
        for (int i = 0; i < UW; i++) if (i < (word >> LW)) t[i] = 1'b1;
        return t;
    endfunction

    task automatic check_one(input string tag, input string inst, input int word,
                             input logic [UW-1:0] up, input logic [UW-1:0] un,
                             input logic [LW-1:0] bp, input logic [LW-1:0] bn);
        logic [UW-1:0] et = therm_of(word);
        logic [LW-1:0] eb = LW'(word);
        n_checks++;
        if (up !== et || un !== ~et || bp !== eb || bn !== ~eb) begin
            n_fail++;
            $display("FAIL %s %s: unary_p=%h unary_n=%h bin_p=%h bin_n=%h expected %h %h %h %h",
                     tag, inst, up, un, bp, bn, et, ~et, eb, ~eb);
        end
    endtask

    // Check both instances, then present a new word and reset level.
    task automatic step(input string tag, input int v, input logic r);
        @(negedge clk);
        check_one(tag, "u0", q0[0], up0, un0, bp0, bn0);
        check_one(tag, "u1", q1[0], up1, un1, bp1, bn1);
        din = DW'(v);
        rst = r;
        @(posedge clk);
        if (r) begin
            q0 = {0, 0, 0};
            q1 = {0, 0};
        end else begin
            q0.push_back(v); void'(q0.pop_front());
            q1.push_back(v); void'(q1.pop_front());
        end
    endtask

    initial begin
        #(8 * 200000);
        n_fail++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        q0 = {0, 0, 0};
        q1 = {0, 0};
        repeat (4) @(posedge clk);
        // R6: code-zero pattern held during reset and just after release
        step("R6", 1023, 1'b1);
        step("R6", 0, 1'b0);
        step("R6", 0, 1'b0);
        // R1 R2 R4: full ramp through every code
        for (int c = 0; c < (1 << DW); c++) step("R2", c, 1'b0);
        // R3 R1: walking ones in binary field under fixed unary values
        for (int m = 0; m < (1 << MW); m += 21)
            for (int j = 0; j < LW; j++) step("R3", (m << LW) | (1 << j), 1'b0);
        // R8: full-scale alternation
        for (int k = 0; k < 10; k++) step("R8", (k % 2) ? (1 << DW) - 1 : 0, 1'b0);
        // R5 R7: pseudo-random stream on both latency settings
        for (int k = 0; k < 600; k++) step("R7", int'($urandom_range((1 << DW) - 1)), 1'b0);
        // R6: reset in the middle of a stream
        step("R6", 777, 1'b0);
        step("R6", 1023, 1'b0);
        step("R6", 1023, 1'b1);
        step("R6", 513, 1'b0);
        for (int k = 0; k < 5; k++) step("R4", 100 + k * 37, 1'b0);
        step("R4", 0, 1'b0);
        step("R4", 0, 1'b0);
        step("R4", 0, 1'b0);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule